// File: doc/BRIEF.md
# Eight-Bit Shared-Adder Arithmetic Unit

This block is an 8-bit arithmetic datapath built around one ripple adder. Two opcode bits pick the mode. Add and subtract are combinational: the 8-bit result appears on the output bus in the same cycle, together with a carry flag and a two's-complement overflow flag. Multiply is sequential. A load strobe captures both operands and clears a 16-bit product register. The unit then runs eight unsigned shift-and-add steps, one per clock. In each step the multiplicand is added into the upper half of the product while the multiplier shifts right.

The result reaches the 16-bit output bus only while the output-enable input is high. The surrounding logic holds the multiply opcode, pulses the load strobe, and waits for the done flag before reading the product.

Top module: `arith8_unit`

## Requirements
- R1: With opcode bit 4 high and bit 0 low (add), while `out_en` is high, `result[7:0]` equals (a + b) mod 256, `result[15:8]` is 0, and `carry` is bit 8 of the unsigned sum, all in the same cycle.
- R2: With opcode bit 4 high and bit 0 high (subtract), `result[7:0]` equals (a - b) mod 256 and `result[15:8]` is 0. `carry` is 1 exactly when a >= b as unsigned values, meaning no borrow occurred.
- R3: In add and subtract modes, `ovf` is 1 exactly when the signed 8-bit result differs from the true signed sum or difference. Two examples: 0x7F + 0x01 gives 0x80 with `ovf` set, and 0x80 - 0x01 gives 0x7F with `ovf` set.
- R4: With opcode bit 4 low and bit 0 high (idle), `result`, `carry` and `ovf` are all 0. Opcode bits 1 to 3 have no effect in any mode.
- R5: While `out_en` is low, `result` is all zeros. The flags are not affected by `out_en`.
- R6: A clock edge with `mul_load` high captures a and b, clears the product and the step count, and drops `done`. From the next cycle, `result` reads 0 in multiply mode.
- R7: After the load, each clock edge in multiply mode (opcode bits 4 and 0 both low) with `mul_load` low performs one step. After eight steps, `result` equals the unsigned 16-bit product a*b and `done` is 1. Both then stay unchanged until the next load or reset.
- R8: In multiply mode, `carry` and `ovf` are 0.
- R9: Steps are taken only in multiply mode. When the opcode leaves multiply mode, the product and the step count hold. When it returns, the sequence resumes, and eight steps in total still give a*b.
- R10: A clock edge with `rst_n` low clears the product, the step count and `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opc | input | 5 | Opcode; bit 4 = arithmetic, bit 0 = subtract/idle select |
| a | input | 8 | Operand A / multiplicand |
| b | input | 8 | Operand B / multiplier |
| mul_load | input | 1 | Synchronous active-high multiply load and clear |
| out_en | input | 1 | Output bus enable |
| result | output | 16 | Gated result bus |
| carry | output | 1 | Carry-out (no-borrow when subtracting) |
| ovf | output | 1 | Two's-complement overflow |
| done | output | 1 | Multiply finished |

## Verification
Add and subtract errors are visible on the bus in the same cycle, so a wrong operand inversion or a wrong carry chain shows at once. An error in the multiply sequence stays hidden until the eighth step. A miscounted step, a missed shift or a lost carry into the product's top bit shows up as a wrong final product or a `done` flag that rises early or late. A step taken while out of multiply mode shows up only when the sequence is paused and resumed. Random operands are mixed with the carry, borrow and overflow corners, and both all-ones and sparse multipliers are used, so these faults reach the ports within one multiply run.

// File: rtl/arith8_pkg.sv
// Package: shared mode type and opcode bit positions for the arithmetic unit.
// Assumes an opcode of at least five bits; only bits 0 and 4 carry meaning.
package arith8_pkg;
    localparam int OPC_W        = 5;
    localparam int OPC_SEL_BIT  = 0;
    localparam int OPC_ARITH_BIT = 4;

    typedef enum logic [1:0] {
        MODE_ADD  = 2'd0,
        MODE_SUB  = 2'd1,
        MODE_MUL  = 2'd2,
        MODE_IDLE = 2'd3
    } mode_t;
endpackage

// File: rtl/arith8_decode.sv
// Decodes the opcode into one of four modes.
// Assumes bits other than the select and arithmetic bits are don't-care.
module arith8_decode
    import arith8_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output mode_t            mode
);
    logic unused_opc_bits;
    assign unused_opc_bits = ^opc[OPC_ARITH_BIT-1:OPC_SEL_BIT+1];

    // Purpose: map the two meaningful opcode bits onto a mode.
    always_comb begin
        unique case ({opc[OPC_ARITH_BIT], opc[OPC_SEL_BIT]})
            2'b10:   mode = MODE_ADD;
            2'b11:   mode = MODE_SUB;
            2'b00:   mode = MODE_MUL;
            default: mode = MODE_IDLE;
        endcase
    end
endmodule

// File: rtl/arith8_adder.sv
// Ripple-carry adder shared by every mode. With sub high it inverts y and
// injects a carry of 1, so it forms x - y. Overflow is the carry into the MSB
// XOR the carry out of it.
// Assumes W >= 2.
module arith8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0]   c;
    logic [W-1:0] yb;

    assign c[0] = sub;
    assign yb   = y ^ {W{sub}};

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: one full-adder cell of the chain.
        assign sum[i]  = x[i] ^ yb[i] ^ c[i];
        assign c[i+1]  = (x[i] & yb[i]) | (c[i] & (x[i] ^ yb[i]));
    end

    assign cout = c[W];
    assign ovf  = c[W] ^ c[W-1];
endmodule

// File: rtl/arith8_mulseq.sv
// Shift-and-add multiply sequencer. It holds the product, the multiplicand,
// the shifting multiplier and a step count. It feeds the upper product half
// and the gated multiplicand to the shared adder. Each enabled step stores
// {carry, sum, low half >> 1}.
// Assumes the adder is in add mode whenever step_en is high.
module arith8_mulseq #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step_en,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   add_sum,
    input  logic           add_cout,
    output logic [W-1:0]   add_x,
    output logic [W-1:0]   add_y,
    output logic [2*W-1:0] product,
    output logic           done
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

    logic [2*W-1:0] acc_q;
    logic [W-1:0]   mcand_q;
    logic [W-1:0]   mplier_q;
    logic [CNT_W-1:0] cnt_q;

    assign done    = (cnt_q == LAST);
    assign product = acc_q;
    assign add_x   = acc_q[2*W-1:W];
    assign add_y   = mplier_q[0] ? mcand_q : '0;

    // Purpose: reset, load, or advance one shift-and-add step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            acc_q    <= '0;
            mcand_q  <= a;
            mplier_q <= b;
            cnt_q    <= '0;
        end else if (step_en && !done) begin
            acc_q    <= {add_cout, add_sum, acc_q[W-1:1]};
            mplier_q <= mplier_q >> 1;
            cnt_q    <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/arith8_outgate.sv
// Selects the result for the current mode and gates it onto the bus.
// Flags are valid in add/subtract only. The bus is zero while disabled.
module arith8_outgate
    import arith8_pkg::*;
#(
    parameter int W = 8
) (
    input  mode_t          mode,
    input  logic           out_en,
    input  logic [W-1:0]   sum,
    input  logic           cout,
    input  logic           ovf_in,
    input  logic [2*W-1:0] product,
    output logic [2*W-1:0] result,
    output logic           carry,
    output logic           ovf
);
    logic [2*W-1:0] sel;

    // Purpose: pick the value and the flags for the active mode.
    always_comb begin
        sel   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (mode)
            MODE_ADD, MODE_SUB: begin
                sel   = {{W{1'b0}}, sum};
                carry = cout;
                ovf   = ovf_in;
            end
            MODE_MUL: sel = product;
            default:  sel = '0;
        endcase
    end

    assign result = out_en ? sel : '0;
endmodule

// File: rtl/arith8_unit.sv
// Top level: decoder, shared adder, multiply sequencer and output gate.
// Assumes synchronous reset and load, and one rising-edge clock.
module arith8_unit
    import arith8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             mul_load,
    input  logic             out_en,
    output logic [2*W-1:0]   result,
    output logic             carry,
    output logic             ovf,
    output logic             done
);
    mode_t          mode;
    logic [W-1:0]   add_x, add_y, sum, mx, my;
    logic           add_sub, cout, ovf_raw;
    logic [2*W-1:0] product;

    arith8_decode u_decode (.opc(opc), .mode(mode));

    // Purpose: steer the shared adder's operands for the active mode.
    always_comb begin
        add_x   = '0;
        add_y   = '0;
        add_sub = 1'b0;
        unique case (mode)
            MODE_ADD: begin add_x = a;  add_y = b; end
            MODE_SUB: begin add_x = a;  add_y = b; add_sub = 1'b1; end
            MODE_MUL: begin add_x = mx; add_y = my; end
            default:  begin add_x = '0; add_y = '0; end
        endcase
    end

    arith8_adder #(.W(W)) u_adder (
        .x(add_x), .y(add_y), .sub(add_sub),
        .sum(sum), .cout(cout), .ovf(ovf_raw)
    );

    arith8_mulseq #(.W(W)) u_mulseq (
        .clk(clk), .rst_n(rst_n), .load(mul_load),
        .step_en(mode == MODE_MUL),
        .a(a), .b(b), .add_sum(sum), .add_cout(cout),
        .add_x(mx), .add_y(my), .product(product), .done(done)
    );

    arith8_outgate #(.W(W)) u_outgate (
        .mode(mode), .out_en(out_en), .sum(sum), .cout(cout),
        .ovf_in(ovf_raw), .product(product),
        .result(result), .carry(carry), .ovf(ovf)
    );
endmodule

// File: rtl/arith8_unit_chk.sv
// Port-level property checker for arith8_unit, attached by bind.
module arith8_unit_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [4:0]     opc,
    input logic           mul_load,
    input logic           out_en,
    input logic [2*W-1:0] result,
    input logic           carry,
    input logic           ovf,
    input logic           done
);
    logic in_mul;
    assign in_mul = !opc[4] && !opc[0];

    // R5
    bus_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> result == '0);

    // R8
    mul_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_mul |-> (!carry && !ovf));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!opc[4] && opc[0]) |-> (result == '0 && !carry && !ovf));

    // R1
    addsub_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc[4] |-> result[2*W-1:W] == '0);

    // R6
    load_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_load |=> !done);

    // R7
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mul_load) |=> done);
endmodule

bind arith8_unit arith8_unit_chk #(.W(W)) u_chk (.*);

// File: tb/arith8_unit_bench.sv
module arith8_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  opc = 5'b00000;
    logic [7:0]  a = '0, b = '0;
    logic        mul_load = 1'b0;
    logic        out_en = 1'b0;
    logic [15:0] result;
    logic        carry, ovf, done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    arith8_unit u_arith8_unit (
        .clk(clk), .rst_n(rst_n), .opc(opc), .a(a), .b(b),
        .mul_load(mul_load), .out_en(out_en),
        .result(result), .carry(carry), .ovf(ovf), .done(done)
    );

    // Expected {ovf, carry, 8-bit value} for add or subtract.
    function automatic logic [9:0] exp_as(input logic [7:0] x, input logic [7:0] y,
                                          input bit sub);
        logic [8:0] full;
        logic [7:0] s;
        logic c, v;
        if (sub) begin
            s = x - y;
            c = (x >= y);
            v = (x[7] != y[7]) && (s[7] != x[7]);
        end else begin
            full = {1'b0, x} + {1'b0, y};
            s = full[7:0];
            c = full[8];
            v = (x[7] == y[7]) && (s[7] != x[7]);
        end
        return {v, c, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply an add/subtract and check bus and flags; junk in bits 1-3.
    task automatic do_as(input logic [7:0] x, input logic [7:0] y, input bit sub);
        logic [9:0] e;
        @(negedge clk);
        opc = {1'b1, 3'($urandom), sub};
        a = x; b = y; out_en = 1'b1;
        #2;
        e = exp_as(x, y, sub);
        chk(sub ? "R2 value" : "R1 value", 32'(result), {24'h0, e[7:0]});
        chk(sub ? "R2 carry" : "R1 carry", 32'(carry), 32'(e[8]));
        chk("R3 overflow", 32'(ovf), 32'(e[9]));
    endtask

    task automatic mul_load_op(input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        opc = 5'b00000; a = x; b = y; mul_load = 1'b1; out_en = 1'b1;
        @(negedge clk);
        mul_load = 1'b0;
        a = 8'($urandom); b = 8'($urandom);
        #2;
        chk("R6 cleared product", 32'(result), 32'h0);
        chk("R6 done low", 32'(done), 32'h0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #2;
    endtask

    task automatic do_mul(input logic [7:0] x, input logic [7:0] y);
        mul_load_op(x, y);
        steps(7);
        chk("R7 done not early", 32'(done), 32'h0);
        steps(1);
        chk("R7 product", 32'(result), 32'(16'(x) * 16'(y)));
        chk("R7 done", 32'(done), 32'h1);
        chk("R8 carry zero", 32'(carry), 32'h0);
        chk("R8 ovf zero", 32'(ovf), 32'h0);
        steps(2);
        chk("R7 product held", 32'(result), 32'(16'(x) * 16'(y)));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; opc = 5'b00000; out_en = 1'b1;
        #2;
        chk("R10 reset product", 32'(result), 32'h0);
        chk("R10 reset done", 32'(done), 32'h0);

        // Directed add/subtract corners.
        do_as(8'h7F, 8'h01, 0);
        do_as(8'h80, 8'h80, 0);
        do_as(8'h80, 8'hFF, 0);
        do_as(8'h55, 8'h55, 0);
        do_as(8'hF8, 8'h88, 0);
        do_as(8'h80, 8'h01, 1);
        do_as(8'h00, 8'h33, 1);
        do_as(8'h6C, 8'h00, 1);
        do_as(8'h7F, 8'hFF, 1);
        do_as(8'h55, 8'h55, 1);
        for (int i = 0; i < 300; i++)
            do_as(8'($urandom), 8'($urandom), 1'($urandom));

        // R4 idle mode.
        @(negedge clk);
        opc = 5'b01111; a = 8'hFF; b = 8'h01; out_en = 1'b1;
        #2;
        chk("R4 idle result", 32'(result), 32'h0);
        chk("R4 idle flags", 32'({carry, ovf}), 32'h0);

        // R5 output disabled, flags unaffected.
        @(negedge clk);
        opc = 5'b10000; a = 8'h80; b = 8'h80; out_en = 1'b0;
        #2;
        chk("R5 bus gated", 32'(result), 32'h0);
        chk("R5 flags still driven", 32'({carry, ovf}), 32'h3);

        // Multiply: directed then random.
        do_mul(8'hFF, 8'hFF);
        do_mul(8'h89, 8'h2A);
        do_mul(8'h00, 8'hC3);
        do_mul(8'h01, 8'h80);
        for (int i = 0; i < 40; i++) do_mul(8'($urandom), 8'($urandom));

        // R9 pause and resume.
        mul_load_op(8'hB7, 8'h6D);
        steps(3);
        @(negedge clk);
        opc = 5'b10000; a = 8'h01; b = 8'h02;
        #2;
        chk("R9 add while paused", 32'(result), 32'h3);
        steps(1);
        @(negedge clk);
        opc = 5'b00000;
        #2;
        chk("R9 not done yet", 32'(done), 32'h0);
        steps(4);
        chk("R9 resumed product", 32'(result), 32'(16'hB7 * 16'h6D));
        chk("R9 done", 32'(done), 32'h1);

        // R10 reset mid-flow.
        mul_load_op(8'hE3, 8'h5A);
        steps(4);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R10 product cleared", 32'(result), 32'h0);
        chk("R10 done cleared", 32'(done), 32'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule